// File: doc/BRIEF.md
# Packed Shift, Logic and Compare Unit

This unit works on one 64-bit word treated as a set of equal lanes of 8, 16 or 32 bits. A single operation selector picks one of three per-lane shifts, four whole-word bitwise functions or two per-lane comparisons. Shifts and comparisons stay strictly inside the selected lane boundaries. A comparison does not return one flag. It fills each lane with all ones when the test holds and with all zeros when it fails, so later code can merge values with AND and OR masks instead of branching.

The operands, shift count and selectors are sampled on a clock edge when the enable input is high. The result is held in an output register until the next enabled edge. The shift count is shared by every lane. Only its low six bits are used, and counts that reach or pass the lane width saturate, so no bit ever crosses into a neighbouring lane.

Top module: `pcsl_unit`

## Requirements
- R1: `lane_sel` picks the lane width: 0 = eight 8-bit lanes, 1 = four 16-bit lanes, 2 = two 32-bit lanes, 3 = two 32-bit lanes (same as 2).
- R2: `op_sel` codes are 0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 AND, 4 AND-NOT, 5 OR, 6 XOR, 7 equal, 8 signed greater-than. The result appears on `res` one rising edge after `en` is high, and `res` holds its value while `en` is low.
- R3: Shift left moves each lane left by the count and fills with zeros. Bits leaving the top of a lane are dropped.
- R4: Logical shift right moves each lane right by the count and fills with zeros from the top of the lane.
- R5: Arithmetic shift right fills each lane from the top with that lane's own most significant bit.
- R6: The count is `shamt[5:0]`, and upper bits of `shamt` are ignored. A count at or above the lane width gives zero for both logical shifts and gives all copies of the lane sign bit for the arithmetic shift.
- R7: AND, OR and XOR act on all 64 bits, and their result does not depend on `lane_sel`.
- R8: AND-NOT gives `(~src_a) & src_b`.
- R9: Equal sets a lane to all ones when the two operand lanes match and to all zeros otherwise.
- R10: Greater-than treats both lanes as signed two's-complement and sets the lane to all ones when the `src_a` lane is strictly larger, and to all zeros otherwise.
- R11: `op_sel` codes 9 to 15 give a zero result.
- R12: While `rst_n` is low, `res` is zero, and it clears at once when `rst_n` falls. Release is synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the result register |
| op_sel | input | 4 | Operation code |
| lane_sel | input | 2 | Lane width select |
| shamt | input | 8 | Shift count; low 6 bits are used |
| src_a | input | 64 | First operand (the value that is shifted) |
| src_b | input | 64 | Second operand |
| res | output | 64 | Registered result |

## Verification
Shift operands put set bits at both edges of every lane, so a bit leaking across a lane boundary or a wrong fill value shows up in the neighbouring lane. The same operand is shifted at each lane width, which separates a wrong lane decode from a wrong shift. Counts of zero, of exactly the lane width, of 63 and with the upper count bits set separate saturation from wrap-around. Compare operands mix equal, unequal, sign-boundary and negative-against-positive lanes, so an unsigned compare or a shared flag gives a different mask.

// File: rtl/pcsl_pkg.sv
`timescale 1ns/1ps
package pcsl_pkg;

  localparam int unsigned WORD_W     = 64;
  localparam int unsigned LANE_MIN_W = 8;
  localparam int unsigned NUM_SZ     = 3;   // 8, 16, 32-bit lane layouts
  localparam int unsigned CNT_W      = 6;
  localparam int unsigned CNT_IN_W   = 8;

  typedef enum logic [3:0] {
    OP_SLL  = 4'd0,
    OP_SRL  = 4'd1,
    OP_SRA  = 4'd2,
    OP_AND  = 4'd3,
    OP_ANDN = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CEQ  = 4'd7,
    OP_CGT  = 4'd8
  } pcsl_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_ANDN = 2'd1,
    LG_OR   = 2'd2,
    LG_XOR  = 2'd3
  } logic_fn_e;

endpackage

// File: rtl/pcsl_shift.sv
`timescale 1ns/1ps
module pcsl_shift
  import pcsl_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned MIN_W = LANE_MIN_W,
  parameter int unsigned NSZ   = NUM_SZ,
  parameter int unsigned AW    = CNT_W
) (
  input  logic [DW-1:0]  din,
  input  logic [AW-1:0]  amt,
  input  logic [1:0]     sz_idx,
  input  shift_kind_e    kind,
  output logic [DW-1:0]  dout
);

  logic [NSZ-1:0][DW-1:0] per_sz;

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int unsigned LW = MIN_W << k;
    localparam int unsigned NL = DW / LW;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      logic [LW-1:0] lane_in;
      logic [LW-1:0] lane_out;
      logic          over;
      assign lane_in = din[j*LW +: LW];
      assign over    = ({1'b0, amt} >= (AW+1)'(LW));
      always_comb begin
        unique case (kind)
          SH_LEFT:  lane_out = over ? '0 : (lane_in << amt);
          SH_RIGHT: lane_out = over ? '0 : (lane_in >> amt);
          SH_ARITH: lane_out = over ? {LW{lane_in[LW-1]}}
                                    : LW'($signed(lane_in) >>> amt);
          default:  lane_out = '0;
        endcase
      end
      assign per_sz[k][j*LW +: LW] = lane_out;
    end
  end

  always_comb begin
    dout = per_sz[0];
    for (int s = 1; s < int'(NSZ); s++) begin
      if (int'(sz_idx) == s) dout = per_sz[s];
    end
  end

endmodule

// File: rtl/pcsl_logic.sv
`timescale 1ns/1ps
module pcsl_logic
  import pcsl_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic_fn_e     fn,
  output logic [DW-1:0] dout
);

  always_comb begin
    unique case (fn)
      LG_AND:  dout = opa & opb;
      LG_ANDN: dout = ~opa & opb;
      LG_OR:   dout = opa | opb;
      LG_XOR:  dout = opa ^ opb;
      default: dout = '0;
    endcase
  end

endmodule

// File: rtl/pcsl_cmp.sv
`timescale 1ns/1ps
module pcsl_cmp
  import pcsl_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned MIN_W = LANE_MIN_W,
  parameter int unsigned NSZ   = NUM_SZ
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [1:0]    sz_idx,
  input  logic          use_gt,
  output logic [DW-1:0] mask
);

  logic [NSZ-1:0][DW-1:0] per_sz;

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int unsigned LW = MIN_W << k;
    localparam int unsigned NL = DW / LW;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      logic [LW-1:0] la;
      logic [LW-1:0] lb;
      logic          hit;
      assign la  = opa[j*LW +: LW];
      assign lb  = opb[j*LW +: LW];
      assign hit = use_gt ? ($signed(la) > $signed(lb)) : (la == lb);
      assign per_sz[k][j*LW +: LW] = {LW{hit}};
    end
  end

  always_comb begin
    mask = per_sz[0];
    for (int s = 1; s < int'(NSZ); s++) begin
      if (int'(sz_idx) == s) mask = per_sz[s];
    end
  end

endmodule

// File: rtl/pcsl_unit.sv
`timescale 1ns/1ps
module pcsl_unit
  import pcsl_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned MIN_W = LANE_MIN_W,
  parameter int unsigned NSZ   = NUM_SZ,
  parameter int unsigned AW    = CNT_W,
  parameter int unsigned SHW   = CNT_IN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [3:0]      op_sel,
  input  logic [1:0]      lane_sel,
  input  logic [SHW-1:0]  shamt,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  output logic [DW-1:0]   res
);

  localparam int unsigned NBYTE = DW / 8;

  // reset: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // operand decode
  logic [AW-1:0]  amt;
  logic [1:0]     sz_idx;
  pcsl_op_e       op;
  shift_kind_e    sh_kind;
  logic_fn_e      lg_fn;
  logic           unused_shamt_hi;

  assign amt             = shamt[AW-1:0];
  assign unused_shamt_hi = ^shamt[SHW-1:AW];
  assign sz_idx          = (lane_sel == 2'd3) ? 2'd2 : lane_sel;
  assign op              = pcsl_op_e'(op_sel);

  always_comb begin
    sh_kind = SH_LEFT;
    lg_fn   = LG_AND;
    unique case (op)
      OP_SRL:  sh_kind = SH_RIGHT;
      OP_SRA:  sh_kind = SH_ARITH;
      OP_ANDN: lg_fn   = LG_ANDN;
      OP_OR:   lg_fn   = LG_OR;
      OP_XOR:  lg_fn   = LG_XOR;
      default: ;
    endcase
  end

  logic [DW-1:0] sh_out;
  logic [DW-1:0] lg_out;
  logic [DW-1:0] cm_out;

  pcsl_shift #(.DW(DW), .MIN_W(MIN_W), .NSZ(NSZ), .AW(AW)) u_shift (
    .din    (src_a),
    .amt    (amt),
    .sz_idx (sz_idx),
    .kind   (sh_kind),
    .dout   (sh_out)
  );

  pcsl_logic #(.DW(DW)) u_logic (
    .opa  (src_a),
    .opb  (src_b),
    .fn   (lg_fn),
    .dout (lg_out)
  );

  pcsl_cmp #(.DW(DW), .MIN_W(MIN_W), .NSZ(NSZ)) u_cmp (
    .opa    (src_a),
    .opb    (src_b),
    .sz_idx (sz_idx),
    .use_gt (op == OP_CGT),
    .mask   (cm_out)
  );

  // next-state
  logic [DW-1:0] res_d;

  always_comb begin
    unique case (op)
      OP_SLL, OP_SRL, OP_SRA:         res_d = sh_out;
      OP_AND, OP_ANDN, OP_OR, OP_XOR: res_d = lg_out;
      OP_CEQ, OP_CGT:                 res_d = cm_out;
      default:                        res_d = '0;
    endcase
  end

  // registers
  logic [DW-1:0] res_q;
  logic          vld_q;
  logic [3:0]    op_q;
  logic [1:0]    sz_q;
  logic [AW-1:0] amt_q;
  logic          same_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      vld_q  <= 1'b0;
      op_q   <= '0;
      sz_q   <= '0;
      amt_q  <= '0;
      same_q <= 1'b0;
    end else if (en) begin
      res_q  <= res_d;
      vld_q  <= 1'b1;
      op_q   <= op_sel;
      sz_q   <= sz_idx;
      amt_q  <= amt;
      same_q <= (src_a == src_b);
    end
  end

  assign res = res_q;

  // assertion helpers
  function automatic logic bytes_are_masks(logic [DW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < int'(NBYTE); i++) begin
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    end
    return ok;
  endfunction

  logic [AW:0] lane_w_q;
  assign lane_w_q = (AW+1)'(MIN_W) << sz_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable(res_q)) else $error("result changed without enable"); // R2

  AST_CMP_IS_MASK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_q && (op_q == 4'd7 || op_q == 4'd8)) |-> bytes_are_masks(res_q))
    else $error("compare result is not a lane mask"); // R9

  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_q && op_q == 4'd7 && same_q) |-> (res_q == '1))
    else $error("equal operands did not give all ones"); // R9

  AST_GT_SELF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_q && op_q == 4'd8 && same_q) |-> (res_q == '0))
    else $error("greater-than of equal operands not zero"); // R10

  AST_SHIFT_SAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_q && (op_q == 4'd0 || op_q == 4'd1) && ({1'b0, amt_q} >= lane_w_q))
    |-> (res_q == '0)) else $error("oversized logical shift not zero"); // R6

  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_q && op_q > 4'd8) |-> (res_q == '0))
    else $error("unused op code gave nonzero result"); // R11

endmodule

// File: tb/pcsl_unit_bench.sv
`timescale 1ns/1ps
module pcsl_unit_bench;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  lsz;
    logic [7:0]  cnt;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    // R3 left shift, 8/16/32-bit lanes
    '{4'd0, 2'd0, 8'd1,  64'h8081_4201_FF00_7F10, 64'h0, 64'h0002_8402_FE00_FE20, 8'd3},
    '{4'd0, 2'd1, 8'd4,  64'h1234_F00F_8001_00FF, 64'h0, 64'h2340_00F0_0010_0FF0, 8'd3},
    '{4'd0, 2'd2, 8'd8,  64'h1234_5678_9ABC_DEF0, 64'h0, 64'h3456_7800_BCDE_F000, 8'd3},
    // R4 logical right
    '{4'd1, 2'd0, 8'd3,  64'h80FF_0108_7F40_2010, 64'h0, 64'h101F_0001_0F08_0402, 8'd4},
    '{4'd1, 2'd2, 8'd16, 64'hDEAD_BEEF_0123_4567, 64'h0, 64'h0000_DEAD_0000_0123, 8'd4},
    // R5 arithmetic right
    '{4'd2, 2'd0, 8'd2,  64'h80FF_0108_7F40_2010, 64'h0, 64'hE0FF_0002_1F10_0804, 8'd5},
    '{4'd2, 2'd1, 8'd4,  64'h8000_7FFF_F00F_0123, 64'h0, 64'hF800_07FF_FF00_0012, 8'd5},
    // R6 saturation and count masking
    '{4'd0, 2'd0, 8'd8,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0,                   8'd6},
    '{4'd2, 2'd1, 8'd63, 64'h8000_7FFF_FFFF_0001, 64'h0, 64'hFFFF_0000_FFFF_0000, 8'd6},
    '{4'd1, 2'd2, 8'd32, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0,                   8'd6},
    '{4'd0, 2'd1, 8'h41, 64'h0001_0001_0001_0001, 64'h0, 64'h0002_0002_0002_0002, 8'd6},
    // R7 bitwise
    '{4'd3, 2'd0, 8'd0,  64'hF0F0_FF00_1234_5678, 64'h0FF0_F0F0_FFFF_0000, 64'h00F0_F000_1234_0000, 8'd7},
    '{4'd5, 2'd1, 8'd0,  64'hF0F0_FF00_1234_5678, 64'h0FF0_F0F0_FFFF_0000, 64'hFFF0_FFF0_FFFF_5678, 8'd7},
    '{4'd6, 2'd2, 8'd0,  64'hF0F0_FF00_1234_5678, 64'h0FF0_F0F0_FFFF_0000, 64'hFF00_0FF0_EDCB_5678, 8'd7},
    // R8 and-not
    '{4'd4, 2'd0, 8'd0,  64'hF0F0_FF00_1234_5678, 64'h0FF0_F0F0_FFFF_0000, 64'h0F00_00F0_EDCB_0000, 8'd8},
    // R9 equal
    '{4'd7, 2'd0, 8'd0,  64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 64'hFFFF_00FF_FF00_FFFF, 8'd9},
    '{4'd7, 2'd1, 8'd0,  64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 64'hFFFF_0000_0000_FFFF, 8'd9},
    '{4'd7, 2'd2, 8'd0,  64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 64'h0,                   8'd9},
    // R10 signed greater-than
    '{4'd8, 2'd0, 8'd0,  64'h7F80_0102_FF00_8001, 64'h8080_0201_0000_7F01, 64'hFF00_00FF_0000_0000, 8'd10},
    '{4'd8, 2'd2, 8'd0,  64'hFFFF_FFFF_0000_0001, 64'h8000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd10},
    '{4'd8, 2'd1, 8'd0,  64'h0000_8000_7FFF_0005, 64'hFFFF_7FFF_8000_0005, 64'hFFFF_0000_FFFF_0000, 8'd10},
    // R11 unused codes
    '{4'd9,  2'd0, 8'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd11},
    '{4'd15, 2'd2, 8'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd11},
    // R1 lane code 3 behaves as 32-bit lanes
    '{4'd1, 2'd3, 8'd16, 64'hDEAD_BEEF_0123_4567, 64'h0, 64'h0000_DEAD_0000_0123, 8'd1}
  };

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [3:0]  op_sel;
  logic [1:0]  lane_sel;
  logic [7:0]  shamt;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic [63:0] res;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pcsl_unit u_pcsl_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .op_sel   (op_sel),
    .lane_sel (lane_sel),
    .shamt    (shamt),
    .src_a    (src_a),
    .src_b    (src_b),
    .res      (res)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_sel   = v.op;
    lane_sel = v.lsz;
    shamt    = v.cnt;
    src_a    = v.a;
    src_b    = v.b;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0;
    op_sel = '0; lane_sel = '0; shamt = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset value", res, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 after release", res, 64'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), res, VEC[i].exp);
    end

    // R2 latency: before the capturing edge the old value remains
    @(negedge clk);
    drive(VEC[0]);
    en = 1'b1;
    #1;
    chk("R2 before edge", res, VEC[NV-1].exp);
    @(negedge clk);
    en = 1'b0;
    chk("R2 after edge", res, VEC[0].exp);

    // R2 hold: inputs change with enable low
    drive(VEC[19]);
    repeat (3) @(negedge clk);
    chk("R2 hold", res, VEC[0].exp);

    // R12 asynchronous clear mid-run
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R12 async clear", res, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    drive(VEC[19]);
    @(negedge clk);
    chk("R12 sync release held", res, 64'h0);
    @(negedge clk);
    @(negedge clk);
    en = 1'b0;
    chk("R12 works after release", res, VEC[19].exp);

    finish_run();
  end

endmodule